// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Error Status

This block receives characters from one asynchronous serial line that is oversampled by a sample-enable tick running at sixteen times the bit rate. It finds the start bit, samples each later bit near its middle and assembles a character of 5 to 8 data bits, sent least significant bit first, with an optional parity bit. For every character it writes two FIFO entries that share one write pointer: the data byte, and a status nibble that classifies the character. The status nibble carries a parity error, a framing error, a line break or an overrun flag, and a character can carry more than one flag at a time.

The host reads the head entry of both FIFOs from the `rd_data` and `rd_stat` ports and pops it with `rd_en`. An exception request is raised while the head entry carries any error flag, so error characters are handed over one at a time. A receive timeout request is raised when good characters have waited for four character times on an idle line. It never fires while any error character is still pending. After a break, the receiver writes exactly one NULL entry and then stays silent until the line has returned high.

Top module: `uart_rx_err`

## Requirements
- R1: A character with a correct parity bit (or no parity) and a stop bit sampled high is stored with status 0. Its data is right-aligned, with bits above the configured length at 0. Length = 5 + `cfg_len`.
- R2: With `cfg_par_en`=1, the parity bit must make the count of ones over data and parity even (`cfg_par_odd`=0) or odd (`cfg_par_odd`=1). On a mismatch, status bit 0 is set and the data is still stored.
- R3: A stop bit sampled low when any data bit or the parity bit is 1 sets status bit 1 (framing), and the data is still stored.
- R4: A stop bit sampled low when all data bits and the parity bit are 0 stores one 0x00 entry with status bit 2 (break). Bit 1 is never set together with bit 2. With odd parity, bit 0 is set as well.
- R5: After a break, no entry is written while the line stays low. Reception resumes only after the line has been high and a new start bit arrives.
- R6: The stop bit length is not checked. A start bit that follows a one-bit-time stop bit is received normally.
- R7: A character that completes while 8 entries are held is dropped, and status bit 3 (overrun) is ORed into the newest stored entry. The count stays at 8.
- R8: `data_count` equals the number of held entries. `exc_req` is 1 exactly when the FIFO is non-empty and the head status is nonzero.
- R9: `tmo_req` rises once the FIFO holds only error-free entries and the receiver has been idle for 4 character times, measured as 4 x 16 x (start + data + parity + stop) ticks. It is never raised while an error entry is held, and it clears on a read.
- R10: A low pulse shorter than half a bit time is not taken as a start bit.
- R11: After reset, `data_count` is 0 and `exc_req` and `tmo_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sample enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data length minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| rd_en | input | 1 | Pop the head entry (ignored when empty) |
| rd_data | output | 8 | Head data byte |
| rd_stat | output | 4 | Head status: bit0 parity, bit1 framing, bit2 break, bit3 overrun |
| data_count | output | 4 | Number of held entries |
| exc_req | output | 1 | Head entry carries an error |
| tmo_req | output | 1 | Receive timeout request |

## Verification
The bench builds the block with its default 8-entry FIFO and 16x oversampling, and drives the tick once every four clocks, so one bit lasts 64 clocks. The small 5-bit character length lets the bench send every data value under all three parity modes. Within that sweep it flips the parity bit and drops the stop bit on an arithmetic pattern, so the good, parity, framing and break classes, and their combinations, all appear. The eight-entry depth makes the overrun path reachable in nine characters. The 10-bit frame gives a timeout window of 2560 clocks, which the bench can observe directly.

// File: rtl/uart_rx_err.sv
module uart_rx_err #(
  parameter int DEPTH = 8,
  parameter int OSR   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick16,
  input  logic                       rxd,
  input  logic [1:0]                 cfg_len,
  input  logic                       cfg_par_en,
  input  logic                       cfg_par_odd,
  input  logic                       rd_en,
  output logic [7:0]                 rd_data,
  output logic [3:0]                 rd_stat,
  output logic [$clog2(DEPTH):0]     data_count,
  output logic                       exc_req,
  output logic                       tmo_req
);
  localparam int AW = $clog2(DEPTH);
  localparam int SW = $clog2(OSR);
  localparam int TW = $clog2(4 * OSR * 12 + 1);
  localparam logic [SW-1:0] MID  = SW'(OSR / 2 - 1);
  localparam logic [SW-1:0] LAST = SW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} st_t;

  logic [1:0]    sync;
  logic          rx;
  st_t           st;
  logic [SW-1:0] scnt;
  logic [2:0]    bcnt;
  logic [7:0]    sh;
  logic          pbit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  assign rx = sync[1];

  logic [3:0] shamt;
  logic [7:0] data_w;
  logic       zero_c, brk, frm, perr, push;

  assign shamt  = 4'd3 - {2'b00, cfg_len};
  assign data_w = sh >> shamt;
  assign zero_c = (data_w == 8'd0) && !(cfg_par_en && pbit);
  assign brk    = !rx && zero_c;
  assign frm    = !rx && !zero_c;
  assign perr   = cfg_par_en && ((^data_w ^ pbit) != cfg_par_odd);
  assign push   = tick16 && (st == S_STOP) && (scnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      scnt <= '0;
      bcnt <= '0;
      sh   <= '0;
      pbit <= 1'b0;
    end else if (tick16) begin
      case (st)
        S_IDLE: if (!rx) begin st <= S_START; scnt <= '0; end
        S_START:
          if (scnt == MID) begin
            scnt <= '0;
            bcnt <= '0;
            pbit <= 1'b0;
            st   <= rx ? S_IDLE : S_DATA;
          end else scnt <= scnt + 1'b1;
        S_DATA:
          if (scnt == LAST) begin
            scnt <= '0;
            sh   <= {rx, sh[7:1]};
            if (bcnt == {1'b0, cfg_len} + 3'd4) st <= cfg_par_en ? S_PAR : S_STOP;
            else bcnt <= bcnt + 1'b1;
          end else scnt <= scnt + 1'b1;
        S_PAR:
          if (scnt == LAST) begin
            scnt <= '0;
            pbit <= rx;
            st   <= S_STOP;
          end else scnt <= scnt + 1'b1;
        S_STOP:
          if (scnt == LAST) begin
            scnt <= '0;
            st   <= brk ? S_BRK : S_IDLE;
          end else scnt <= scnt + 1'b1;
        S_BRK: if (rx) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [7:0]    dmem [DEPTH];
  logic [3:0]    smem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          full, pop, wr;

  assign full = (cnt == (AW+1)'(DEPTH));
  assign pop  = rd_en && (cnt != '0);
  assign wr   = push && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        dmem[i] <= '0;
        smem[i] <= '0;
      end
    end else begin
      if (wr) begin
        dmem[wp] <= data_w;
        smem[wp] <= {1'b0, brk, frm, perr};
        wp       <= wp + 1'b1;
      end else if (push) begin
        smem[wp - 1'b1][3] <= 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(wr) - (AW+1)'(pop);
    end
  end

  logic any_err;
  always_comb begin
    any_err = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (((AW+1)'(i) < cnt) && (smem[rp + AW'(i)] != 4'd0)) any_err = 1'b1;
  end

  logic [3:0]    char_bits;
  logic [TW-1:0] tmo_thr, tmo_cnt;
  logic          tmo_arm;

  assign char_bits = 4'd7 + {2'b00, cfg_len} + {3'b000, cfg_par_en};
  assign tmo_thr   = TW'(char_bits) * TW'(4 * OSR);
  assign tmo_arm   = (st == S_IDLE) && (cnt != '0) && !any_err && !push && !pop;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                   tmo_cnt <= '0;
    else if (!tmo_arm)                            tmo_cnt <= '0;
    else if (tick16 && (tmo_cnt < tmo_thr))       tmo_cnt <= tmo_cnt + 1'b1;

  assign rd_data    = dmem[rp];
  assign rd_stat    = smem[rp];
  assign data_count = cnt;
  assign exc_req    = (cnt != '0) && (smem[rp] != 4'd0);
  assign tmo_req    = (tmo_cnt >= tmo_thr) && (cnt != '0) && !any_err;
endmodule

// File: rtl/uart_rx_err_chk.sv
module uart_rx_err_chk #(
  parameter int DEPTH = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rd_en,
  input logic [7:0]             rd_data,
  input logic [3:0]             rd_stat,
  input logic [$clog2(DEPTH):0] data_count,
  input logic                   exc_req,
  input logic                   tmo_req
);
  assert_break_null_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_count != 0 && rd_stat[2]) |-> rd_data == 8'd0);

  assert_frame_break_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_count != 0) |-> !(rd_stat[1] && rd_stat[2]));

  assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_count == DEPTH && !rd_en) |=> data_count == DEPTH);

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_count <= DEPTH);

  assert_no_tmo_on_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_req |-> !exc_req);

  assert_empty_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_count == 0) |-> (!exc_req && !tmo_req));
endmodule

bind uart_rx_err uart_rx_err_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data), .rd_stat(rd_stat),
  .data_count(data_count), .exc_req(exc_req), .tmo_req(tmo_req)
);

// File: tb/uart_rx_err_tb_top.sv
module uart_rx_err_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len = 2'd0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [3:0] rd_stat;
  logic [3:0] data_count;
  logic       exc_req, tmo_req;

  int checks = 0;
  int errors = 0;
  int tdiv = 0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
    tick16 <= (tdiv == 3);
  end

  uart_rx_err dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .rd_en(rd_en),
    .rd_data(rd_data), .rd_stat(rd_stat), .data_count(data_count),
    .exc_req(exc_req), .tmo_req(tmo_req)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic b, input int ticks);
    rxd = b;
    repeat (ticks * 4) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int len, input logic pe, input logic pb,
                      input logic stop, input int idle_bits);
    hold(1'b0, 16);
    for (int i = 0; i < len; i++) hold(d[i], 16);
    if (pe) hold(pb, 16);
    hold(stop, 16);
    rxd = 1'b1;
    if (idle_bits > 0) hold(1'b1, 16 * idle_bits);
  endtask

  task automatic read_check(input logic [7:0] ed, input logic [3:0] es, input string req);
    chk(rd_data, ed, req);
    chk(rd_stat, es, req);
    chk(exc_req, es != 4'd0, {req, "/R8"});
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic par_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(data_count, 0, "R11");
    chk(exc_req, 0, "R11");
    chk(tmo_req, 0, "R11");

    // R1 R2 R3 R4: 5-bit sweep under all parity modes
    cfg_len = 2'd0;
    for (int m = 0; m < 3; m++) begin
      cfg_par_en  = (m != 0);
      cfg_par_odd = (m == 2);
      for (int v = 0; v < 32; v++) begin
        logic cp, pb, stop, zero;
        logic [3:0] es;
        cp   = cfg_par_en ? par_of(8'(v), cfg_par_odd) : 1'b0;
        pb   = cp ^ (v % 5 == 2);
        stop = (v % 7 != 0);
        zero = (v == 0) && !(cfg_par_en && pb);
        es   = {1'b0, !stop && zero, !stop && !zero, cfg_par_en && (pb != cp)};
        send(8'(v), 5, cfg_par_en, pb, stop, 2);
        chk(data_count, 1, "R8");
        read_check(8'(v), es, "R1/R2/R3/R4");
        chk(data_count, 0, "R8");
      end
    end

    // R1 R2: longer lengths, even parity
    cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    for (int l = 1; l < 4; l++) begin
      cfg_len = 2'(l);
      for (int k = 0; k < 8; k++) begin
        logic [7:0] v;
        logic pb;
        v  = 8'((k * 37 + 11) & ((1 << (l + 5)) - 1));
        pb = par_of(v, 1'b0) ^ (k == 5);
        send(v, l + 5, 1'b1, pb, 1'b1, 2);
        read_check(v, (k == 5) ? 4'h1 : 4'h0, "R1/R2");
      end
    end

    // R4 R5: break with odd parity, line kept low, then recovery
    cfg_len = 2'd2; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
    send(8'h00, 7, 1'b1, 1'b0, 1'b0, 0);
    hold(1'b0, 16 * 12);
    chk(data_count, 1, "R5");
    hold(1'b1, 32);
    send(8'h41, 7, 1'b1, par_of(8'h41, 1'b1), 1'b1, 2);
    chk(data_count, 2, "R5");
    read_check(8'h00, 4'h5, "R4");
    read_check(8'h41, 4'h0, "R5");

    // R6: one-bit stop, back to back
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    send(8'hA5, 8, 1'b0, 1'b0, 1'b1, 0);
    send(8'h3C, 8, 1'b0, 1'b0, 1'b1, 2);
    chk(data_count, 2, "R6");
    read_check(8'hA5, 4'h0, "R6");
    read_check(8'h3C, 4'h0, "R6");

    // R10: short glitch
    hold(1'b0, 4);
    hold(1'b1, 40);
    chk(data_count, 0, "R10");

    // R7: overrun
    for (int i = 0; i < 9; i++) send(8'(i * 17 + 3), 8, 1'b0, 1'b0, 1'b1, 1);
    chk(data_count, 8, "R7");
    for (int i = 0; i < 8; i++)
      read_check(8'(i * 17 + 3), (i == 7) ? 4'h8 : 4'h0, "R7");
    chk(data_count, 0, "R7");

    // R9: timeout on good data only
    send(8'h5A, 8, 1'b0, 1'b0, 1'b1, 0);
    repeat (1200) @(negedge clk);
    chk(tmo_req, 0, "R9");
    repeat (2000) @(negedge clk);
    chk(tmo_req, 1, "R9");
    read_check(8'h5A, 4'h0, "R9");
    chk(tmo_req, 0, "R9");
    send(8'h11, 8, 1'b0, 1'b0, 1'b1, 0);
    send(8'h22, 8, 1'b0, 1'b0, 1'b0, 0);
    repeat (4000) @(negedge clk);
    chk(tmo_req, 0, "R9");
    read_check(8'h11, 4'h0, "R9");
    chk(tmo_req, 0, "R9");
    read_check(8'h22, 4'h2, "R3");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule